// File: doc/BRIEF.md
# Ternary Prefix Lookup Table

This block is a small ternary match table. Each slot holds a stored pattern, a per-bit care mask and a short result code. A write port fills or clears one slot at a time, chosen by index. A search port presents a key together with a per-bit key mask. Every valid slot is compared with the key at the same time, and the block reports the outcome one clock later. The outcome has four parts: a hit flag, the index of the winning slot, the result code of that slot, and a vector that shows every slot that matched.

When more than one slot matches, the lowest index wins. Software keeps routing prefixes in slots ordered from the longest prefix to the shortest, with the host bits marked as don't-care. With that ordering, the winning slot is the longest-prefix match for the key.

Top module: `tcam_lookup`

## Requirements
- R1: A stored care bit of 0 makes that bit position match either key value. Care bit 1 means the bit is compared. A slot whose low five bits are 1,0,X,X,0 (bits 4 down to 0) and whose other bits are all cared matches exactly the four keys 16, 18, 20 and 22 among the keys 0 to 31.
- R2: A slot matches only if every bit that is cared for in both the slot and the key equals the key bit. One differing bit in such a position means the slot does not match.
- R3: The search key mask works per bit, with 1 meaning compare and 0 meaning exclude. An excluded key bit is ignored in every slot.
- R4: A slot with its valid bit clear never matches. Reset clears every valid bit. A write with `wr_keep` = 0 invalidates the addressed slot.
- R5: When several slots match, `rsp_idx` is the lowest matching index.
- R6: If slots hold prefixes in order of decreasing prefix length, the reported slot is the longest-prefix match for the key.
- R7: Bit i of `rsp_matches` is 1 exactly when slot i matched the key.
- R8: When no slot matches, `rsp_hit` is 0 and both `rsp_idx` and `rsp_result` are 0.
- R9: The response appears on the clock edge after a search is presented, with `rsp_valid` = 1. In a cycle with no search presented, every response output is 0 after the next edge. All response outputs are 0 after reset.
- R10: A search and a write in the same cycle see the slot contents from before the write. A search in the following cycle sees the new contents.
- R11: On a hit, `rsp_result` equals the result code stored in the winning slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write the addressed slot |
| wr_keep | input | 1 | Valid bit to store: 1 loads the slot, 0 invalidates it |
| wr_idx | input | 4 | Slot index for the write |
| wr_value | input | 32 | Stored pattern |
| wr_care | input | 32 | Stored care mask, 1 = compare |
| wr_result | input | 8 | Result code stored with the slot |
| srch_en | input | 1 | Search request |
| srch_key | input | 32 | Search key |
| srch_care | input | 32 | Key mask, 1 = compare |
| rsp_valid | output | 1 | Response for the search of the previous cycle |
| rsp_hit | output | 1 | At least one slot matched |
| rsp_idx | output | 4 | Lowest matching slot index |
| rsp_result | output | 8 | Result code of the winning slot |
| rsp_matches | output | 16 | One bit per matching slot |

## Verification
A stored 10XX0 pattern is searched with all 32 low-bit keys. This shows whether stored don't-care bits are honoured without any extra matches. Keys with a single flipped bit, with and without the key mask covering that bit, separate the stored-mask path from the key-mask path. Overlapping wildcard slots and slots invalidated by a write show whether the winner is chosen by index priority. A table sorted by prefix length is checked against an independent reference that picks the match by length. Random patterns and keys then exercise the full match vector and the result mux together.

// File: rtl/tcam_pkg.sv
package tcam_pkg;
  localparam int DEF_SLOTS = 16;
  localparam int DEF_KEY_W = 32;
  localparam int DEF_RES_W = 8;
endpackage

// File: rtl/tcam_store.sv
module tcam_store #(
  parameter int SLOTS = tcam_pkg::DEF_SLOTS,
  parameter int KEY_W = tcam_pkg::DEF_KEY_W,
  parameter int RES_W = tcam_pkg::DEF_RES_W,
  localparam int IDX_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         wr_en,
  input  logic                         wr_keep,
  input  logic [IDX_W-1:0]             wr_idx,
  input  logic [KEY_W-1:0]             wr_value,
  input  logic [KEY_W-1:0]             wr_care,
  input  logic [RES_W-1:0]             wr_result,
  output logic [SLOTS-1:0]             slot_live,
  output logic [SLOTS-1:0][KEY_W-1:0]  slot_value,
  output logic [SLOTS-1:0][KEY_W-1:0]  slot_care,
  output logic [SLOTS-1:0][RES_W-1:0]  slot_result
);
  always_ff @(posedge clk) begin
    if (rst) begin
      slot_live <= '0;
    end else if (wr_en && (int'(wr_idx) < SLOTS)) begin
      slot_live[wr_idx] <= wr_keep;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en && (int'(wr_idx) < SLOTS)) begin
      slot_value[wr_idx]  <= wr_value;
      slot_care[wr_idx]   <= wr_care;
      slot_result[wr_idx] <= wr_result;
    end
  end

  AST_CLEAR_DROPS_SLOT: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_keep && (int'(wr_idx) < SLOTS)) |=> !slot_live[$past(wr_idx)]); // R4
endmodule

// File: rtl/tcam_compare.sv
module tcam_compare #(
  parameter int SLOTS = tcam_pkg::DEF_SLOTS,
  parameter int KEY_W = tcam_pkg::DEF_KEY_W
) (
  input  logic [SLOTS-1:0]             slot_live,
  input  logic [SLOTS-1:0][KEY_W-1:0]  slot_value,
  input  logic [SLOTS-1:0][KEY_W-1:0]  slot_care,
  input  logic [KEY_W-1:0]             key,
  input  logic [KEY_W-1:0]             key_care,
  output logic [SLOTS-1:0]             hits
);
  for (genvar g = 0; g < SLOTS; g++) begin : g_line
    logic [KEY_W-1:0] diff;
    assign diff    = (slot_value[g] ^ key) & slot_care[g] & key_care;
    assign hits[g] = slot_live[g] && (diff == '0);
  end
endmodule

// File: rtl/tcam_priority.sv
module tcam_priority #(
  parameter int SLOTS = tcam_pkg::DEF_SLOTS,
  localparam int IDX_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic [SLOTS-1:0] hits,
  output logic             found,
  output logic [IDX_W-1:0] win
);
  always_comb begin
    win = '0;
    for (int i = SLOTS - 1; i >= 0; i--) begin
      if (hits[i]) win = IDX_W'(i);
    end
    found = |hits;
  end
endmodule

// File: rtl/tcam_lookup.sv
module tcam_lookup #(
  parameter int SLOTS = tcam_pkg::DEF_SLOTS,
  parameter int KEY_W = tcam_pkg::DEF_KEY_W,
  parameter int RES_W = tcam_pkg::DEF_RES_W,
  localparam int IDX_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             wr_keep,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [KEY_W-1:0] wr_value,
  input  logic [KEY_W-1:0] wr_care,
  input  logic [RES_W-1:0] wr_result,
  input  logic             srch_en,
  input  logic [KEY_W-1:0] srch_key,
  input  logic [KEY_W-1:0] srch_care,
  output logic             rsp_valid,
  output logic             rsp_hit,
  output logic [IDX_W-1:0] rsp_idx,
  output logic [RES_W-1:0] rsp_result,
  output logic [SLOTS-1:0] rsp_matches
);
  logic [SLOTS-1:0]             slot_live;
  logic [SLOTS-1:0][KEY_W-1:0]  slot_value;
  logic [SLOTS-1:0][KEY_W-1:0]  slot_care;
  logic [SLOTS-1:0][RES_W-1:0]  slot_result;
  logic [SLOTS-1:0]             hits;
  logic                         found;
  logic [IDX_W-1:0]             win;

  tcam_store #(.SLOTS(SLOTS), .KEY_W(KEY_W), .RES_W(RES_W)) u_store (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_keep(wr_keep), .wr_idx(wr_idx),
    .wr_value(wr_value), .wr_care(wr_care), .wr_result(wr_result),
    .slot_live(slot_live), .slot_value(slot_value), .slot_care(slot_care),
    .slot_result(slot_result)
  );

  tcam_compare #(.SLOTS(SLOTS), .KEY_W(KEY_W)) u_cmp (
    .slot_live(slot_live), .slot_value(slot_value), .slot_care(slot_care),
    .key(srch_key), .key_care(srch_care), .hits(hits)
  );

  tcam_priority #(.SLOTS(SLOTS)) u_prio (
    .hits(hits), .found(found), .win(win)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid   <= 1'b0;
      rsp_hit     <= 1'b0;
      rsp_idx     <= '0;
      rsp_result  <= '0;
      rsp_matches <= '0;
    end else begin
      rsp_valid   <= srch_en;
      rsp_hit     <= srch_en && found;
      rsp_idx     <= (srch_en && found) ? win : '0;
      rsp_result  <= (srch_en && found) ? slot_result[win] : '0;
      rsp_matches <= srch_en ? hits : '0;
    end
  end

  AST_HIT_AGREES_VECTOR: assert property (@(posedge clk) disable iff (rst)
    rsp_hit == (rsp_matches != '0)); // R7
  AST_WINNER_IS_LOWEST: assert property (@(posedge clk) disable iff (rst)
    rsp_hit |-> (rsp_matches[rsp_idx] &&
      ((rsp_matches & ((SLOTS'(1) << rsp_idx) - SLOTS'(1))) == '0))); // R5
  AST_MISS_IS_ZERO: assert property (@(posedge clk) disable iff (rst)
    !rsp_hit |-> (rsp_idx == '0 && rsp_result == '0)); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !rsp_valid |-> (rsp_matches == '0 && !rsp_hit)); // R9
  AST_DEAD_SLOT_SILENT: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((rsp_matches & ~$past(slot_live)) == '0)); // R4
endmodule

// File: tb/tcam_lookup_test.sv
`timescale 1ns/100ps
module tcam_lookup_test;
  logic clk = 0;
  logic rst = 1;
  logic wr_en = 0, wr_keep = 0;
  logic [3:0] wr_idx = 0;
  logic [31:0] wr_value = 0, wr_care = 0;
  logic [7:0] wr_result = 0;
  logic srch_en = 0;
  logic [31:0] srch_key = 0, srch_care = 0;
  logic rsp_valid, rsp_hit;
  logic [3:0] rsp_idx;
  logic [7:0] rsp_result;
  logic [15:0] rsp_matches;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic        m_live [16];
  logic [31:0] m_val [16];
  logic [31:0] m_care [16];
  logic [7:0]  m_res [16];

  always #2.5 clk = ~clk;

  tcam_lookup uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_keep(wr_keep), .wr_idx(wr_idx),
    .wr_value(wr_value), .wr_care(wr_care), .wr_result(wr_result),
    .srch_en(srch_en), .srch_key(srch_key), .srch_care(srch_care),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_idx(rsp_idx),
    .rsp_result(rsp_result), .rsp_matches(rsp_matches)
  );

  function automatic logic [29:0] model(input logic [31:0] k, input logic [31:0] kc);
    logic [15:0] mv = '0;
    logic [3:0] idx = '0;
    logic [7:0] res = '0;
    bit got = 0;
    for (int i = 0; i < 16; i++) begin
      if (m_live[i] && (((m_val[i] ^ k) & m_care[i] & kc) == 32'h0)) begin
        mv[i] = 1'b1;
        if (!got) begin got = 1; idx = 4'(i); res = m_res[i]; end
      end
    end
    return {1'b1, got ? 1'b1 : 1'b0, idx, res, mv};
  endfunction

  function automatic logic [29:0] observed();
    return {rsp_valid, rsp_hit, rsp_idx, rsp_result, rsp_matches};
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int idx, input logic [31:0] v, input logic [31:0] c,
                    input logic [7:0] r, input bit keep);
    @(negedge clk);
    wr_en = 1; wr_keep = keep; wr_idx = 4'(idx);
    wr_value = v; wr_care = c; wr_result = r;
    @(posedge clk);
    #1 wr_en = 0;
    m_live[idx] = keep; m_val[idx] = v; m_care[idx] = c; m_res[idx] = r;
  endtask

  task automatic clear_all();
    for (int i = 0; i < 16; i++) wr(i, 32'h0, 32'h0, 8'h0, 0);
  endtask

  task automatic search(input logic [31:0] k, input logic [31:0] kc,
                        output logic [29:0] got, output logic [29:0] exp);
    @(negedge clk);
    srch_en = 1; srch_key = k; srch_care = kc;
    exp = model(k, kc);
    @(posedge clk);
    #1 srch_en = 0;
    @(negedge clk);
    got = observed();
  endtask

  initial begin
    logic [29:0] got, exp;
    int nhit;
    void'($urandom(20240611));
    for (int i = 0; i < 16; i++) begin
      m_live[i] = 0; m_val[i] = 0; m_care[i] = 0; m_res[i] = 0;
    end
    repeat (3) @(posedge clk);
    #1 rst = 0;
    @(negedge clk);
    chk("R9 reset outputs", 64'(observed()), 64'h0);

    // R4: after reset every slot is invalid, even a fully wildcarded search misses
    search(32'h1234_5678, 32'h0, got, exp);
    chk("R4 R8 empty after reset", 64'(got), 64'({1'b1, 29'h0}));

    // R1: 10XX0 in bits 4..0
    wr(3, 32'h0000_0010, 32'hFFFF_FFF9, 8'hA3, 1);
    nhit = 0;
    for (int k = 0; k < 32; k++) begin
      search(32'(k), 32'hFFFF_FFFF, got, exp);
      chk("R1 ternary pattern", 64'(got), 64'(exp));
      if (got[28]) nhit++;
      if (k == 16 || k == 18 || k == 20 || k == 22)
        chk("R1 R11 listed key hits", 64'({got[28], got[23:16]}), 64'({1'b1, 8'hA3}));
    end
    chk("R1 hit count", 64'(nhit), 64'd4);

    // R2 / R3: single differing bit
    clear_all();
    wr(5, 32'hC0DE_F00D, 32'hFFFF_FFFF, 8'h55, 1);
    for (int b = 0; b < 32; b += 7) begin
      search(32'hC0DE_F00D ^ (32'h1 << b), 32'hFFFF_FFFF, got, exp);
      chk("R2 one bit off misses", 64'(got), 64'({1'b1, 29'h0}));
      search(32'hC0DE_F00D ^ (32'h1 << b), ~(32'h1 << b), got, exp);
      chk("R3 key mask hides bit", 64'(got), 64'({1'b1, 1'b1, 4'd5, 8'h55, 16'h0020}));
    end

    // R5 / R11 / R4: overlapping wildcards
    wr(1, 32'h0, 32'h0, 8'h11, 1);
    wr(6, 32'h0, 32'h0, 8'h66, 1);
    search(32'hDEAD_BEEF, 32'hFFFF_FFFF, got, exp);
    chk("R5 R7 lowest wins", 64'(got), 64'({1'b1, 1'b1, 4'd1, 8'h11, 16'h0042}));
    wr(1, 32'h0, 32'h0, 8'h11, 0);
    search(32'hDEAD_BEEF, 32'hFFFF_FFFF, got, exp);
    chk("R4 invalidated slot skipped", 64'(got), 64'({1'b1, 1'b1, 4'd6, 8'h66, 16'h0040}));

    // R10: write and search in the same cycle
    @(negedge clk);
    wr_en = 1; wr_keep = 1; wr_idx = 4'd0; wr_value = 32'h0; wr_care = 32'h0; wr_result = 8'h77;
    srch_en = 1; srch_key = 32'h1; srch_care = 32'hFFFF_FFFF;
    exp = model(32'h1, 32'hFFFF_FFFF);
    @(posedge clk);
    #1 wr_en = 0; srch_en = 0;
    m_live[0] = 1; m_val[0] = 0; m_care[0] = 0; m_res[0] = 8'h77;
    @(negedge clk);
    chk("R10 search sees old contents", 64'(observed()), 64'(exp));
    search(32'h1, 32'hFFFF_FFFF, got, exp);
    chk("R10 next search sees write", 64'(got), 64'({1'b1, 1'b1, 4'd0, 8'h77, 16'h0041}));

    // R9: no search presented
    @(negedge clk);
    chk("R9 idle outputs zero", 64'(observed()), 64'h0);

    // R6: prefixes in decreasing length, compared with a length-based reference
    begin
      logic [31:0] base, pm [16], pf [16];
      int len [16];
      base = $urandom;
      for (int i = 0; i < 16; i++) begin
        len[i] = 30 - 2 * i;
        pm[i] = (len[i] == 0) ? 32'h0 : (32'hFFFF_FFFF << (32 - len[i]));
        pf[i] = base & pm[i];
        wr(i, pf[i], pm[i], 8'(8'h80 + i), 1);
      end
      for (int t = 0; t < 60; t++) begin
        logic [31:0] key;
        int best, blen;
        key = base ^ ($urandom >> ($urandom % 32));
        best = -1; blen = -1;
        for (int i = 0; i < 16; i++)
          if (((key & pm[i]) == pf[i]) && len[i] > blen) begin best = i; blen = len[i]; end
        search(key, 32'hFFFF_FFFF, got, exp);
        chk("R6 longest prefix", 64'({got[28], got[27:24]}), 64'({1'b1, 4'(best)}));
      end
    end

    // R7 / R11 / R2 / R3: random table and keys
    for (int i = 0; i < 16; i++)
      wr(i, $urandom, $urandom | $urandom, 8'($urandom), ($urandom % 5) != 0);
    for (int t = 0; t < 400; t++) begin
      logic [31:0] key, kc;
      int j;
      j = $urandom % 16;
      key = m_val[j] ^ ($urandom & ~m_care[j]);
      if ($urandom % 3 == 0) key = key ^ (32'h1 << ($urandom % 32));
      kc = ($urandom % 2) ? 32'hFFFF_FFFF : ($urandom | $urandom | $urandom);
      search(key, kc, got, exp);
      chk("R7 R11 random lookup", 64'(got), 64'(exp));
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog R9 actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule